// File: doc/BRIEF.md
# Debug Power Control and Status Registers

This block holds the two small registers through which a debug host brings a processor's debug logic into use. An 8-bit control register asks for the core, memory and debug domains to be woken, holds the core and the debug logic in reset, and carries an enable bit for debug use. An 8-bit status register reports which domains are powered and whether the core is still needed. It also holds two sticky flags that record a completed core reset and a completed debug-logic reset.

The host reaches both registers through a single-cycle request port. Reads are answered one cycle later. A status read may also ask for the sticky flags to be cleared once their value has been returned. Access to the rest of the debug register space is granted only after the enable bit makes a fresh 0-to-1 transition while the debug logic is out of reset. While no grant is held, such accesses are answered with an error pulse.

Top module: `dbgpwr_regs`

## Requirements
- R1: After reset, `pwr_ctrl` is 0x00, `access_granted` is 0, `rsp_valid` is 0, and a status read with all domain inputs low returns 0x40 (debug-was-reset set, core-was-reset clear).
- R2: A write with `req_sel`=0 stores `req_wdata` into the control register, which appears on `pwr_ctrl` after the next clock edge. Bits 3 and 5 are reserved and read as 0. Bit 0 is core wake, bit 1 memory wake, bit 2 debug wake, bit 4 core reset, bit 6 debug reset and bit 7 debug-use enable. A write with `req_sel`=1 has no effect on the control register.
- R3: A status read (`req_sel`=1) returns bit 0 `core_dom_on`, bit 1 `mem_dom_on`, bit 2 `dbg_dom_on`, bit 3 `core_needed`, bit 4 core-was-reset and bit 6 debug-was-reset. Bits 5 and 7 read as 0. Domain bits show the inputs in the request cycle.
- R4: `access_granted` rises only after a control write that takes bit 7 from 0 to 1, with bit 6 of that write 0, bit 6 of the old value 0, and `dbg_rst_in` low.
- R5: A control write with bit 7 = 0 drops the grant. A write with bit 7 = 1 while bit 7 is already set keeps the grant unchanged and never creates one.
- R6: While `dbg_rst_in` or control bit 6 is high, the grant is dropped by the next edge.
- R7: Core-was-reset is set when the core reset (`core_rst_in` OR control bit 4) is released, and it stays set across later reads that do not clear it.
- R8: Debug-was-reset is set when the debug reset (`dbg_rst_in` OR control bit 6) is released, and it stays set until it is cleared.
- R9: A status read with `req_clear`=1 returns the current flags and then clears both of them. If a release occurs in the same cycle, it sets its flag again (set wins).
- R10: `dbg_acc_err` is high in the cycle after `dbg_acc_valid` exactly when no grant was held in the request cycle. Otherwise it is low.
- R11: `rsp_valid` pulses in the cycle after each read request and stays low after writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Host request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 1 | 0 = control register, 1 = status register |
| req_wdata | input | 8 | Write data |
| req_clear | input | 1 | Clear sticky flags after a status read |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 8 | Read data |
| dbg_acc_valid | input | 1 | Access to other debug registers |
| dbg_acc_err | output | 1 | That access was refused |
| core_rst_in | input | 1 | External core reset, active high |
| dbg_rst_in | input | 1 | External debug-logic reset, active high |
| core_dom_on | input | 1 | Core domain powered |
| mem_dom_on | input | 1 | Memory domain powered |
| dbg_dom_on | input | 1 | Debug domain powered |
| core_needed | input | 1 | Core still needed |
| pwr_ctrl | output | 8 | Current control register |
| access_granted | output | 1 | Debug access granted |

## Verification
On every cycle, the assertions check the following: how the grant may rise, that it falls on a clearing write or a debug reset, the error answer to debug accesses, the response strobe timing, and the reserved bits. Some behaviour only the bench's scenarios can show. This covers the full sweep of control values with its sequence-dependent grant. It also covers the sticky flags being set by releases and kept across plain reads, and a set winning over a same-cycle clear. Finally, it covers the rule that rewriting 1 to an already-set enable after a debug reset never restores access.

// File: rtl/dbgpwr_pkg.sv
package dbgpwr_pkg;
    localparam int REG_W = 8;

    localparam int C_CORE_WAKE = 0;
    localparam int C_MEM_WAKE  = 1;
    localparam int C_DBG_WAKE  = 2;
    localparam int C_CORE_RST  = 4;
    localparam int C_DBG_RST   = 6;
    localparam int C_USE       = 7;

    localparam int S_CORE_ON   = 0;
    localparam int S_MEM_ON    = 1;
    localparam int S_DBG_ON    = 2;
    localparam int S_NEEDED    = 3;
    localparam int S_CORE_WAS  = 4;
    localparam int S_DBG_WAS   = 6;

    localparam logic [REG_W-1:0] CTRL_MASK =
        REG_W'((1 << C_CORE_WAKE) | (1 << C_MEM_WAKE) | (1 << C_DBG_WAKE) |
               (1 << C_CORE_RST) | (1 << C_DBG_RST) | (1 << C_USE));

    typedef struct packed {
        logic [REG_W-1:0] ctrl;
        logic             granted;
    } ctrl_state_t;

    typedef struct packed {
        logic core_was;
        logic dbg_was;
        logic core_rst_prev;
        logic dbg_rst_prev;
    } sticky_state_t;

    typedef struct packed {
        logic             rsp_valid;
        logic [REG_W-1:0] rdata;
        logic             acc_err;
    } port_state_t;
endpackage

// File: rtl/dbgpwr_ctrl.sv
module dbgpwr_ctrl
    import dbgpwr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic             dbg_rst_in,
    output logic [REG_W-1:0] ctrl_o,
    output logic             granted_o
);
    ctrl_state_t st_d, st_q;
    logic dbg_hold;
    logic use_rise;

    always_comb begin
        st_d     = st_q;
        dbg_hold = dbg_rst_in | st_q.ctrl[C_DBG_RST];
        use_rise = wr_en & wdata[C_USE] & ~st_q.ctrl[C_USE];
        if (wr_en) begin
            st_d.ctrl = wdata & CTRL_MASK;
        end
        if (dbg_hold) begin
            st_d.granted = 1'b0;
        end else if (wr_en && !wdata[C_USE]) begin
            st_d.granted = 1'b0;
        end else if (use_rise && !wdata[C_DBG_RST]) begin
            st_d.granted = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o    = st_q.ctrl;
    assign granted_o = st_q.granted;
endmodule

// File: rtl/dbgpwr_sticky.sv
module dbgpwr_sticky
    import dbgpwr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic core_rst_eff,
    input  logic dbg_rst_eff,
    input  logic clr,
    output logic core_was_o,
    output logic dbg_was_o
);
    sticky_state_t st_d, st_q;

    always_comb begin
        st_d               = st_q;
        st_d.core_rst_prev = core_rst_eff;
        st_d.dbg_rst_prev  = dbg_rst_eff;
        if (clr) begin
            st_d.core_was = 1'b0;
            st_d.dbg_was  = 1'b0;
        end
        if (st_q.core_rst_prev && !core_rst_eff) begin
            st_d.core_was = 1'b1;
        end
        if (st_q.dbg_rst_prev && !dbg_rst_eff) begin
            st_d.dbg_was = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q               <= '0;
            st_q.dbg_was       <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign core_was_o = st_q.core_was;
    assign dbg_was_o  = st_q.dbg_was;
endmodule

// File: rtl/dbgpwr_port.sv
module dbgpwr_port
    import dbgpwr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic             rd_sel,
    input  logic [REG_W-1:0] ctrl_word,
    input  logic [REG_W-1:0] stat_word,
    input  logic             acc_valid,
    input  logic             granted,
    output logic             rsp_valid_o,
    output logic [REG_W-1:0] rdata_o,
    output logic             acc_err_o
);
    port_state_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = rd_en;
        if (rd_en) begin
            st_d.rdata = rd_sel ? stat_word : ctrl_word;
        end
        st_d.acc_err = acc_valid & ~granted;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid_o = st_q.rsp_valid;
    assign rdata_o     = st_q.rdata;
    assign acc_err_o   = st_q.acc_err;
endmodule

// File: rtl/dbgpwr_regs.sv
module dbgpwr_regs
    import dbgpwr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_sel,
    input  logic [REG_W-1:0] req_wdata,
    input  logic             req_clear,
    output logic             rsp_valid,
    output logic [REG_W-1:0] rsp_rdata,
    input  logic             dbg_acc_valid,
    output logic             dbg_acc_err,
    input  logic             core_rst_in,
    input  logic             dbg_rst_in,
    input  logic             core_dom_on,
    input  logic             mem_dom_on,
    input  logic             dbg_dom_on,
    input  logic             core_needed,
    output logic [REG_W-1:0] pwr_ctrl,
    output logic             access_granted
);
    logic             ctrl_wr;
    logic             rd_en;
    logic             stat_clr;
    logic             core_was;
    logic             dbg_was;
    logic [REG_W-1:0] stat_word;

    assign ctrl_wr  = req_valid & req_write & ~req_sel;
    assign rd_en    = req_valid & ~req_write;
    assign stat_clr = rd_en & req_sel & req_clear;

    dbgpwr_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ctrl_wr),
        .wdata     (req_wdata),
        .dbg_rst_in(dbg_rst_in),
        .ctrl_o    (pwr_ctrl),
        .granted_o (access_granted)
    );

    dbgpwr_sticky u_sticky (
        .clk         (clk),
        .rst_n       (rst_n),
        .core_rst_eff(core_rst_in | pwr_ctrl[C_CORE_RST]),
        .dbg_rst_eff (dbg_rst_in | pwr_ctrl[C_DBG_RST]),
        .clr         (stat_clr),
        .core_was_o  (core_was),
        .dbg_was_o   (dbg_was)
    );

    always_comb begin
        stat_word             = '0;
        stat_word[S_CORE_ON]  = core_dom_on;
        stat_word[S_MEM_ON]   = mem_dom_on;
        stat_word[S_DBG_ON]   = dbg_dom_on;
        stat_word[S_NEEDED]   = core_needed;
        stat_word[S_CORE_WAS] = core_was;
        stat_word[S_DBG_WAS]  = dbg_was;
    end

    dbgpwr_port u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (rd_en),
        .rd_sel     (req_sel),
        .ctrl_word  (pwr_ctrl),
        .stat_word  (stat_word),
        .acc_valid  (dbg_acc_valid),
        .granted    (access_granted),
        .rsp_valid_o(rsp_valid),
        .rdata_o    (rsp_rdata),
        .acc_err_o  (dbg_acc_err)
    );
endmodule

// File: rtl/dbgpwr_regs_chk.sv
module dbgpwr_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_write,
    input logic       req_sel,
    input logic [7:0] req_wdata,
    input logic       rsp_valid,
    input logic [7:0] rsp_rdata,
    input logic       dbg_acc_valid,
    input logic       dbg_acc_err,
    input logic       dbg_rst_in,
    input logic [7:0] pwr_ctrl,
    input logic       access_granted
);
    assert_rsv_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_sel) |=> (pwr_ctrl[3] == 1'b0 && pwr_ctrl[5] == 1'b0));

    assert_rsv_stat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_sel) |=> (rsp_rdata[5] == 1'b0 && rsp_rdata[7] == 1'b0));

    assert_grant_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(access_granted) |-> $past(req_valid && req_write && !req_sel && req_wdata[7]
                                        && !req_wdata[6] && !pwr_ctrl[7] && !pwr_ctrl[6]
                                        && !dbg_rst_in));

    assert_use_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_sel && !req_wdata[7]) |=> !access_granted);

    assert_dbg_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_rst_in || pwr_ctrl[6]) |=> !access_granted);

    assert_acc_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_acc_valid |=> (dbg_acc_err == !$past(access_granted)));

    assert_no_acc_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_acc_valid |=> !dbg_acc_err);

    assert_rsp_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    assert_rsp_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);
endmodule

bind dbgpwr_regs dbgpwr_regs_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_sel       (req_sel),
    .req_wdata     (req_wdata),
    .rsp_valid     (rsp_valid),
    .rsp_rdata     (rsp_rdata),
    .dbg_acc_valid (dbg_acc_valid),
    .dbg_acc_err   (dbg_acc_err),
    .dbg_rst_in    (dbg_rst_in),
    .pwr_ctrl      (pwr_ctrl),
    .access_granted(access_granted)
);

// File: tb/sim_dbgpwr_regs.sv
`timescale 1ns/1ps
module sim_dbgpwr_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0, req_sel = 1'b0, req_clear = 1'b0;
    logic [7:0] req_wdata = '0;
    logic       rsp_valid;
    logic [7:0] rsp_rdata;
    logic       dbg_acc_valid = 1'b0, dbg_acc_err;
    logic       core_rst_in = 1'b0, dbg_rst_in = 1'b0;
    logic       core_dom_on = 1'b0, mem_dom_on = 1'b0, dbg_dom_on = 1'b0, core_needed = 1'b0;
    logic [7:0] pwr_ctrl;
    logic       access_granted;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dbgpwr_regs u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_sel(req_sel), .req_wdata(req_wdata), .req_clear(req_clear),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .dbg_acc_valid(dbg_acc_valid), .dbg_acc_err(dbg_acc_err),
        .core_rst_in(core_rst_in), .dbg_rst_in(dbg_rst_in),
        .core_dom_on(core_dom_on), .mem_dom_on(mem_dom_on), .dbg_dom_on(dbg_dom_on),
        .core_needed(core_needed), .pwr_ctrl(pwr_ctrl), .access_granted(access_granted)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] v);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_sel = sel; req_wdata = v;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic sel, input logic clr, output logic [7:0] d, output logic v);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_sel = sel; req_clear = clr;
        @(negedge clk);
        req_valid = 1'b0; req_clear = 1'b0;
        v = rsp_valid;
        d = rsp_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic       v;
        logic [7:0] old_c;
        logic       gexp;

        idle(3);
        // R1: reset state
        chk("R1 pwr_ctrl", 32'(pwr_ctrl), 32'h00);
        chk("R1 granted", 32'(access_granted), 32'h0);
        chk("R1 rsp_valid", 32'(rsp_valid), 32'h0);
        @(negedge clk) rst_n = 1'b1;
        rd(1'b1, 1'b1, d, v);
        chk("R1 status after reset", 32'(d), 32'h40);
        chk("R11 read strobe", 32'(v), 32'h1);
        rd(1'b1, 1'b0, d, v);
        chk("R9 flags cleared by clearing read", 32'(d), 32'h00);

        // R11: writes give no response
        wr(1'b0, 8'h00);
        chk("R11 no strobe on write", 32'(rsp_valid), 32'h0);

        // R2 R4 R5 R6: sweep of all control values in order
        old_c = 8'h00;
        gexp  = 1'b0;
        for (int i = 0; i < 256; i++) begin
            logic [7:0] val;
            val = 8'(i);
            wr(1'b0, val);
            chk("R2 pwr_ctrl", 32'(pwr_ctrl), 32'(val & 8'hD7));
            rd(1'b0, 1'b0, d, v);
            chk("R2 ctrl readback", 32'(d), 32'(val & 8'hD7));
            if (old_c[6] || val[6] || !val[7]) gexp = 1'b0;
            else if (!old_c[7]) gexp = 1'b1;
            chk("R4 R5 R6 grant after write", 32'(access_granted), 32'(gexp));
            old_c = val & 8'hD7;
        end

        // R2: write to status address ignored
        wr(1'b0, 8'h07);
        wr(1'b1, 8'hFF);
        chk("R2 status write ignored", 32'(pwr_ctrl), 32'h07);

        // R3: domain inputs sweep, flags cleared first
        idle(3);
        rd(1'b1, 1'b1, d, v);
        for (int k = 0; k < 16; k++) begin
            logic [3:0] s;
            s = 4'(k);
            @(negedge clk);
            core_dom_on = s[0]; mem_dom_on = s[1]; dbg_dom_on = s[2]; core_needed = s[3];
            rd(1'b1, 1'b0, d, v);
            chk("R3 status domain bits", 32'(d), 32'({4'b0000, s}));
        end
        @(negedge clk);
        core_dom_on = 1'b0; mem_dom_on = 1'b0; dbg_dom_on = 1'b0; core_needed = 1'b0;

        // R4: enable blocked by debug reset input
        wr(1'b0, 8'h00);
        @(negedge clk) dbg_rst_in = 1'b1;
        wr(1'b0, 8'h80);
        idle(1);
        chk("R4 no grant in debug reset", 32'(access_granted), 32'h0);
        @(negedge clk) dbg_rst_in = 1'b0;
        idle(2);
        // R5: rewriting 1 to a set bit does not grant
        wr(1'b0, 8'h80);
        chk("R5 rewrite 1 gives no grant", 32'(access_granted), 32'h0);
        // R8: release of debug reset input set the flag
        rd(1'b1, 1'b0, d, v);
        chk("R8 debug-was-reset set", 32'(d[6]), 32'h1);
        rd(1'b1, 1'b0, d, v);
        chk("R8 debug-was-reset sticky", 32'(d[6]), 32'h1);
        rd(1'b1, 1'b1, d, v);
        wr(1'b0, 8'h00);
        wr(1'b0, 8'h80);
        chk("R4 grant on fresh rise", 32'(access_granted), 32'h1);
        wr(1'b0, 8'h87);
        chk("R5 rewrite 1 keeps grant", 32'(access_granted), 32'h1);

        // R10: debug accesses
        @(negedge clk) dbg_acc_valid = 1'b1;
        @(negedge clk) dbg_acc_valid = 1'b0;
        chk("R10 granted access no error", 32'(dbg_acc_err), 32'h0);
        @(negedge clk) dbg_rst_in = 1'b1;
        @(negedge clk) dbg_rst_in = 1'b0;
        chk("R6 debug reset drops grant", 32'(access_granted), 32'h0);
        @(negedge clk) dbg_acc_valid = 1'b1;
        @(negedge clk) dbg_acc_valid = 1'b0;
        chk("R10 refused access errors", 32'(dbg_acc_err), 32'h1);
        @(negedge clk);
        chk("R10 error is a pulse", 32'(dbg_acc_err), 32'h0);

        // R7: core reset input release
        rd(1'b1, 1'b1, d, v);
        @(negedge clk) core_rst_in = 1'b1;
        idle(2);
        rd(1'b1, 1'b1, d, v);
        rd(1'b1, 1'b0, d, v);
        chk("R7 no flag while reset held", 32'(d[4]), 32'h0);
        @(negedge clk) core_rst_in = 1'b0;
        rd(1'b1, 1'b0, d, v);
        chk("R7 core-was-reset set", 32'(d[4]), 32'h1);
        rd(1'b1, 1'b0, d, v);
        chk("R7 core-was-reset sticky", 32'(d[4]), 32'h1);
        rd(1'b1, 1'b1, d, v);
        chk("R9 clearing read returns flag", 32'(d[4]), 32'h1);
        rd(1'b1, 1'b0, d, v);
        chk("R9 flag cleared", 32'(d[4]), 32'h0);

        // R7: core reset via control bit 4
        wr(1'b0, 8'h10);
        wr(1'b0, 8'h00);
        idle(1);
        rd(1'b1, 1'b0, d, v);
        chk("R7 ctrl core reset release", 32'(d[4]), 32'h1);
        rd(1'b1, 1'b1, d, v);

        // R9: same-cycle release and clear, set wins
        @(negedge clk) core_rst_in = 1'b1;
        idle(2);
        rd(1'b1, 1'b1, d, v);
        @(negedge clk);
        core_rst_in = 1'b0;
        req_valid = 1'b1; req_write = 1'b0; req_sel = 1'b1; req_clear = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; req_clear = 1'b0;
        chk("R9 returned before set", 32'(rsp_rdata[4]), 32'h0);
        rd(1'b1, 1'b0, d, v);
        chk("R9 set wins over clear", 32'(d[4]), 32'h1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule